// File: doc/BRIEF.md
# Dual-Clock Flop FIFO with Clock-Ratio Handshake Modes

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. The producer pushes a word with a one-cycle strobe and is held off by a full flag. The consumer watches an available flag and pops with a one-cycle strobe. Each side keeps its own slot index. The index is published to the other domain as a Gray code and passes through a two-stage synchronizer there. Each side computes its flag only from its own index and the synchronized index of the other side.

The number of slots is one more than the usable depth, which may be 3, 5, 7 or 15. For the 5-entry case the ring has six slots and uses a Johnson-style code, so every step, including the wrap, flips exactly one bit. The storage is a flop array with a read multiplexer.

A compile-time switch picks the handshake timing. In fast-write mode the writer publishes its new index one write clock after the data is stored, and the head word sits on the read port while available is high. In slow-write mode the index is published on the same edge as the data, and a pop loads the word into an output register, so the word appears on the cycle after the pop. Either mode is safe at any clock ratio. A mode that does not match the ratio only costs throughput.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with no loss or duplication, across many wraps of the slot ring.
- R2: With no pops, exactly DEPTH pushes are accepted and wr_full is then high. DEPTH must be 3, 5, 7 or 15, and any other value stops elaboration.
- R3: A push while wr_full is high stores nothing and leaves the write index unchanged.
- R4: A pop while rd_avail is low consumes nothing and leaves the read index unchanged.
- R5: With WR_FAST=1, rd_data shows the head word during every read cycle in which rd_avail is high, and a pop in that cycle consumes it.
- R6: With WR_FAST=0, rd_data changes only on a read edge that has an accepted pop. It then shows the popped word from the next read cycle on, and holds it until the next accepted pop.
- R7: Each published Gray index changes in at most one bit per clock of its own domain, including the step from the last slot back to slot 0.
- R8: While rst_n is low and after it is released, wr_full and rd_avail are low. In WR_FAST=0 mode rd_data is zero.
- R9: After an accepted push, rd_avail rises within a few read clocks. After an accepted pop from a full FIFO, wr_full falls within a few write clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_push | input | 1 | Push strobe, write domain |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot, so pushes are ignored |
| rd_pop | input | 1 | Pop strobe, read domain |
| rd_data | output | DATA_W | Head word (WR_FAST=1) or last popped word (WR_FAST=0) |
| rd_avail | output | 1 | At least one word can be popped |

## Verification
The assertions assume the following about the inputs:
- rst_n is low before the first clock edge.
- wr_push and rd_pop change only between edges of their own clocks.

Given those, a strobe seen while the matching flag blocks it must leave the index stable, and the published codes must move one bit at a time. The bench drives every strobe on the falling edge of its own clock and holds it for exactly one cycle. It runs two configurations: six slots in fast-write mode, and eight slots in slow-write mode. With those, the odd ring, the power-of-two ring and both handshake timings are all covered.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   localparam int CODE_W = 5;
   typedef logic [CODE_W-1:0] code_t;

   // Gray code for a ring of nslot entries; six slots use a Johnson sequence
   function automatic code_t gray_enc(input int nslot, input int idx);
      int v;
      if (nslot == 6) begin
         if (idx <= 3) v = (1 << idx) - 1;
         else          v = 7 & ~((1 << (idx - 3)) - 1);
      end else begin
         v = idx ^ (idx >> 1);
      end
      return code_t'(v);
   endfunction

   function automatic int gray_dec(input int nslot, input code_t g);
      int r;
      r = 0;
      for (int i = 0; i < 16; i++)
         if (i < nslot && gray_enc(nslot, i) == g) r = i;
      return r;
   endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/dcf_ptr.sv
module dcf_ptr
   import dcf_pkg::*;
#(
   parameter int NSLOT   = 6,
   parameter int AW      = 3,
   parameter bit PUB_LAG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] idx,
   output logic [AW-1:0] gray
);
   logic [AW-1:0] idx_nx;
   logic [AW-1:0] enc_src;
   logic [AW-1:0] enc_val;

   assign idx_nx  = (idx == AW'(NSLOT - 1)) ? '0 : idx + 1'b1;
   assign enc_val = AW'(gray_enc(NSLOT, int'(enc_src)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= idx_nx;
   end

   generate
      if (PUB_LAG) begin : g_lag
         // publish the index one clock after it moved
         assign enc_src = idx;
      end else begin : g_now
         // publish on the same edge the index moves
         assign enc_src = adv ? idx_nx : idx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gray <= '0;
      else        gray <= enc_val;
   end

   // R7
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
   parameter int DW    = 8,
   parameter int NSLOT = 6,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [NSLOT];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
   import dcf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 7,
   parameter bit WR_FAST = 1'b1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_push,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail
);
   localparam int NSLOT = DEPTH + 1;
   localparam int AW    = $clog2(NSLOT);

   generate
      if (!(DEPTH == 3 || DEPTH == 5 || DEPTH == 7 || DEPTH == 15)) begin : g_bad_depth
         // R2
         $error("dcf_fifo: DEPTH must be 3, 5, 7 or 15");
      end
   endgenerate

   logic [AW-1:0] wr_idx, wr_gray, wr_idx_nx, rd_idx_w, rg_s;
   logic [AW-1:0] rd_idx, rd_gray, wr_idx_r, wg_s;
   logic          wr_adv, rd_adv;
   logic [DATA_W-1:0] head;

   assign wr_adv = wr_push && !wr_full;
   assign rd_adv = rd_pop && rd_avail;

   dcf_ptr #(.NSLOT(NSLOT), .AW(AW), .PUB_LAG(WR_FAST)) u_wptr (
      .clk(wr_clk), .rst_n(rst_n), .adv(wr_adv), .idx(wr_idx), .gray(wr_gray));

   dcf_ptr #(.NSLOT(NSLOT), .AW(AW), .PUB_LAG(1'b0)) u_rptr (
      .clk(rd_clk), .rst_n(rst_n), .adv(rd_adv), .idx(rd_idx), .gray(rd_gray));

   dcf_sync #(.W(AW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wg_s));
   dcf_sync #(.W(AW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rg_s));

   assign wr_idx_r  = AW'(gray_dec(NSLOT, code_t'(wg_s)));
   assign rd_idx_w  = AW'(gray_dec(NSLOT, code_t'(rg_s)));
   assign wr_idx_nx = (wr_idx == AW'(NSLOT - 1)) ? '0 : wr_idx + 1'b1;
   assign wr_full   = (wr_idx_nx == rd_idx_w);
   assign rd_avail  = (wr_idx_r != rd_idx);

   dcf_store #(.DW(DATA_W), .NSLOT(NSLOT), .AW(AW)) u_mem (
      .clk(wr_clk), .we(wr_adv), .waddr(wr_idx), .wdata(wr_data),
      .raddr(rd_idx), .rdata(head));

   generate
      if (WR_FAST) begin : g_fast_rd
         assign rd_data = head;
      end else begin : g_slow_rd
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge rd_clk or negedge rst_n) begin
            if (!rst_n)      rd_q <= '0;
            else if (rd_adv) rd_q <= head;
         end
         assign rd_data = rd_q;

         // R6
         rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
            !$past(rd_pop && rd_avail) |-> $stable(rd_data));
      end
   endgenerate

   // R3
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_push && wr_full) |=> $stable(wr_idx));

   // R4
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_pop && !rd_avail) |=> $stable(rd_idx));
endmodule

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
   logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic       push [2];
   logic       pop  [2];
   logic       full [2];
   logic       avail[2];
   logic [7:0] wdat [2];
   logic [7:0] rdat [2];
   logic [7:0] exp_q[$];
   logic [7:0] last_pop;
   int total = 0, fails = 0;

   always #10 wr_clk = ~wr_clk;
   always #17 rd_clk = ~rd_clk;

   // k=0: six-slot ring, fast-write; k=1: eight-slot ring, slow-write
   dcf_fifo #(.DATA_W(8), .DEPTH(5), .WR_FAST(1'b1)) u0 (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_push(push[0]), .wr_data(wdat[0]), .wr_full(full[0]),
      .rd_pop(pop[0]), .rd_data(rdat[0]), .rd_avail(avail[0]));

   dcf_fifo #(.DATA_W(8), .DEPTH(7), .WR_FAST(1'b0)) u1 (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_push(push[1]), .wr_data(wdat[1]), .wr_full(full[1]),
      .rd_pop(pop[1]), .rd_data(rdat[1]), .rd_avail(avail[1]));

   function automatic int dep(input int k);
      return (k == 0) ? 5 : 7;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push1(input int k, input logic [7:0] d, output bit acc);
      @(negedge wr_clk);
      acc = !full[k];
      push[k] = 1'b1;
      wdat[k] = d;
      if (acc) exp_q.push_back(d);
      @(negedge wr_clk);
      push[k] = 1'b0;
   endtask

   task automatic pop1(input int k, output bit got, output logic [7:0] d);
      @(negedge rd_clk);
      got = avail[k];
      if (k == 1 && got) chk(rdat[1] == last_pop, "R6 hold before pop", rdat[1], last_pop);
      d = rdat[k];
      pop[k] = 1'b1;
      @(negedge rd_clk);
      pop[k] = 1'b0;
      if (k == 1) d = rdat[1];
      if (got) last_pop = d;
   endtask

   task automatic pop_cmp(input int k, output bit got);
      logic [7:0] d, e;
      pop1(k, got, d);
      if (got) begin
         e = exp_q.pop_front();
         chk(d == e, (k == 0) ? "R1/R5 order" : "R1/R6 order", d, e);
      end
   endtask

   task automatic run_cfg(input int k);
      bit acc, got;
      int n_acc, n_pop;
      logic [7:0] d;
      exp_q.delete();
      last_pop = 8'h00;
      // pop on empty
      pop1(k, got, d);
      chk(got == 1'b0, "R4 pop on empty", got, 0);
      // fill past capacity
      n_acc = 0;
      for (int i = 0; i < dep(k) + 2; i++) begin
         push1(k, 8'(k * 64 + i + 1), acc);
         if (acc) n_acc++;
         if (i >= dep(k)) chk(acc == 1'b0, "R3 push while full", acc, 0);
      end
      chk(n_acc == dep(k), "R2 accepted count", n_acc, dep(k));
      chk(full[k] == 1'b1, "R2 full flag", full[k], 1);
      repeat (6) @(negedge rd_clk);
      chk(avail[k] == 1'b1, "R9 avail after push", avail[k], 1);
      pop_cmp(k, got);
      repeat (6) @(negedge wr_clk);
      chk(full[k] == 1'b0, "R9 full clears", full[k], 0);
      // drain
      n_pop = 1;
      got = 1'b1;
      while (got) begin
         pop_cmp(k, got);
         if (got) n_pop++;
      end
      chk(n_pop == dep(k), "R3/R4 drained count", n_pop, dep(k));
      chk(exp_q.size() == 0, "R1 nothing left", exp_q.size(), 0);
      // indices untouched by ignored strobes: next word comes out intact
      push1(k, 8'hA5, acc);
      repeat (6) @(negedge rd_clk);
      pop_cmp(k, got);
      chk(got == 1'b1, "R4 pop after refill", got, 1);
      // concurrent stream, many wraps
      fork
         begin
            for (int i = 0; i < 60; i++) begin
               acc = 1'b0;
               while (!acc) push1(k, 8'(i * 3 + k), acc);
            end
         end
         begin
            int cnt = 0;
            bit g;
            while (cnt < 60) begin
               pop_cmp(k, g);  // R7 wraps the Gray ring repeatedly
               if (g) cnt++;
            end
         end
      join
      chk(exp_q.size() == 0, "R1/R7 stream complete", exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         push[k] = 1'b0; pop[k] = 1'b0; wdat[k] = 8'h00;
      end
      repeat (3) @(negedge wr_clk);
      for (int k = 0; k < 2; k++) begin
         chk(full[k] == 1'b0, "R8 full in reset", full[k], 0);
         chk(avail[k] == 1'b0, "R8 avail in reset", avail[k], 0);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge rd_clk);
      chk(rdat[1] == 8'h00, "R8 slow data reset", rdat[1], 0);
      chk(avail[0] == 1'b0 && full[1] == 1'b0, "R8 after release", avail[0], 0);
      run_cfg(0);
      run_cfg(1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule